// File: doc/BRIEF.md
# Dual-Channel PWM Run Supervisor

This block is the supervisory sequencer for a controller with two PWM channels: an auxiliary channel that builds a bootstrap supply, and a main channel that runs from it. It takes digitized status flags: supply and reference health, input under- and overvoltage, the bootstrap supply level relative to the main supply and to a low reset level, and one output-undervoltage flag per channel. From these it decides when each channel may switch. It also raises a request to discharge the soft-start capacitor whenever the auxiliary channel is stopped.

The enable pin is qualified by a polarity pin, and both pass through two-flop synchronizers. There are two classes of fault. An ordinary fault (supply low, reference bad, input under- or overvoltage, or disabled) stops both channels. They restart on their own once the fault is gone and the bootstrap supply has fallen to its low level. An output-undervoltage condition that lasts a full timer window latches a fault. That fault clears only after both undervoltage flags drop, followed by a toggle of the enable or the undervoltage input while the bootstrap supply is low. A digital counter replaces the analog delay capacitor.

Top module: `pwm_run_supervisor`

## Requirements
- R1: The effective enable is `en_pin` when `pol_pin` is 0, and the inverse of `en_pin` when `pol_pin` is 1; switching is permitted only while the effective enable is 1.
- R2: While running, any ordinary fault (`supply_ok`=0, `ref_ok`=0, `uv_ok`=0, `ov_trip`=1 or effective enable 0) drops `run_aux` and `run_main` at the next clock edge.
- R3: From the stopped state, `run_aux` rises one edge after a cycle with no ordinary fault and `boot_low`=1.
- R4: `run_main` rises only while `run_aux` is high and only after a cycle with `boot_above_main`=1; it is never high without `run_aux`.
- R5: After an ordinary fault clears, neither run output rises until `boot_low` is 1.
- R6: `ss_discharge` is 1 exactly when `run_aux` is 0, including during reset.
- R7: While running, if `fb_uv_aux` or `fb_uv_main` is 1 on DELAY_CYCLES consecutive edges, both runs drop at the DELAY_CYCLES-th edge and a latched fault is held.
- R8: If both output-undervoltage flags are 0 on an edge before the terminal count, the timer returns to zero with no fault; a new episode needs a full DELAY_CYCLES again.
- R9: The latched fault holds both runs low while either undervoltage flag is 1, and afterwards until the effective enable or `uv_ok` changes while `boot_low` is 1; the normal start of R3 then follows.
- R10: A change at `en_pin` or `pol_pin` takes effect on the run outputs at the third clock edge after it (two synchronizer stages plus the state register).
- R11: Synchronous active-high `rst` forces both run outputs to 0, and the sequencer to the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above start threshold |
| ref_ok | input | 1 | Reference within tolerance |
| uv_ok | input | 1 | Input line above undervoltage threshold |
| ov_trip | input | 1 | Input line above overvoltage threshold |
| boot_above_main | input | 1 | Bootstrap supply exceeds main supply |
| boot_low | input | 1 | Bootstrap supply below reset level |
| fb_uv_aux | input | 1 | Auxiliary output undervoltage flag |
| fb_uv_main | input | 1 | Main output undervoltage flag |
| en_pin | input | 1 | Asynchronous enable pin |
| pol_pin | input | 1 | Asynchronous enable-polarity pin |
| run_aux | output | 1 | Auxiliary channel may switch |
| run_main | output | 1 | Main channel may switch |
| ss_discharge | output | 1 | Soft-start discharge request |

## Verification
Status flags reach the run outputs one edge after they are applied, and enable or polarity changes reach them three edges later. So every vector holds its inputs for at least that latency before the outputs are compared, one time unit after an edge. The undervoltage timer is probed on both sides of its terminal count: at DELAY_CYCLES-1 consecutive flagged edges the runs must still be high, and at the next edge they must be low. The enable latency is checked the same way, at two edges (no change) and at three (change).

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AUX   = 3'd1,
        ST_BOTH  = 3'd2,
        ST_LATCH = 3'd3,
        ST_HOLD  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic supply_ok;
        logic ref_ok;
        logic uv_ok;
        logic ov_trip;
        logic permit;
    } health_t;

    function automatic logic enable_permits(input logic en, input logic pol);
        return pol ? !en : en;
    endfunction

    function automatic logic ordinary_fault(input health_t h);
        return !h.supply_ok || !h.ref_ok || !h.uv_ok || h.ov_trip || !h.permit;
    endfunction

    function automatic logic is_running(input seq_state_t s);
        return (s == ST_AUX) || (s == ST_BOTH);
    endfunction

endpackage

// File: rtl/sup_pin_sync.sv
module sup_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sup_uv_timer.sv
module sup_uv_timer #(
    parameter int DELAY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic fb_any,
    output logic trip
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(DELAY_CYCLES);

    logic             active;
    logic [CNT_W-1:0] cnt_q;

    assign active = running && fb_any;
    assign trip   = active && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active)  cnt_q <= '0;
        else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);                                   // R7
    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0));                      // R8
endmodule

// File: rtl/sup_run_fsm.sv
module sup_run_fsm
    import sup_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  health_t health,
    input  logic    boot_above_main,
    input  logic    boot_low,
    input  logic    fb_any,
    input  logic    trip,
    output logic    running,
    output logic    run_aux,
    output logic    run_main,
    output logic    ss_discharge
);
    seq_state_t state_q, state_d;
    logic       permit_q, uv_q;
    logic       fault, toggle;

    assign fault  = ordinary_fault(health);
    assign toggle = (health.permit != permit_q) || (health.uv_ok != uv_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!fault && boot_low) state_d = ST_AUX;
            ST_AUX: begin
                if (trip)                 state_d = ST_LATCH;
                else if (fault)           state_d = ST_IDLE;
                else if (boot_above_main) state_d = ST_BOTH;
            end
            ST_BOTH: begin
                if (trip)       state_d = ST_LATCH;
                else if (fault) state_d = ST_IDLE;
            end
            ST_LATCH: if (!fb_any)            state_d = ST_HOLD;
            ST_HOLD:  if (boot_low && toggle) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            permit_q <= 1'b0;
            uv_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            permit_q <= health.permit;
            uv_q     <= health.uv_ok;
        end
    end

    assign running      = is_running(state_q);
    assign run_aux      = running;
    assign run_main     = (state_q == ST_BOTH);
    assign ss_discharge = !running;

    AST_FAULT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (running && fault) |=> !run_aux);                // R2
    AST_START_NEEDS_BOOTLOW: assert property (@(posedge clk) disable iff (rst)
        $rose(run_aux) |-> $past(boot_low));             // R5
    AST_MAIN_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(run_main) |-> $past(boot_above_main));     // R4
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCH && fb_any) |=> (state_q == ST_LATCH)); // R9
endmodule

// File: rtl/pwm_run_supervisor.sv
module pwm_run_supervisor
    import sup_pkg::*;
#(
    parameter int DELAY_CYCLES = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic ref_ok,
    input  logic uv_ok,
    input  logic ov_trip,
    input  logic boot_above_main,
    input  logic boot_low,
    input  logic fb_uv_aux,
    input  logic fb_uv_main,
    input  logic en_pin,
    input  logic pol_pin,
    output logic run_aux,
    output logic run_main,
    output logic ss_discharge
);
    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pins_sync;
    health_t          health;
    logic             running, trip, fb_any;

    sup_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({pol_pin, en_pin}),
        .sync_out (pins_sync)
    );

    assign fb_any = fb_uv_aux || fb_uv_main;

    always_comb begin
        health.supply_ok = supply_ok;
        health.ref_ok    = ref_ok;
        health.uv_ok     = uv_ok;
        health.ov_trip   = ov_trip;
        health.permit    = enable_permits(pins_sync[0], pins_sync[1]);  // R1
    end

    sup_uv_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .fb_any  (fb_any),
        .trip    (trip)
    );

    sup_run_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .health          (health),
        .boot_above_main (boot_above_main),
        .boot_low        (boot_low),
        .fb_any          (fb_any),
        .trip            (trip),
        .running         (running),
        .run_aux         (run_aux),
        .run_main        (run_main),
        .ss_discharge    (ss_discharge)
    );

    AST_MAIN_NEEDS_AUX: assert property (@(posedge clk) disable iff (rst)
        run_main |-> run_aux);                           // R4
    AST_DISCHARGE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(run_aux) |-> ss_discharge);                // R6
endmodule

// File: tb/pwm_run_supervisor_test.sv
module pwm_run_supervisor_test;
    localparam int DELAY = 16;
    localparam int NVEC  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok, ref_ok, uv_ok, ov_trip, boot_above_main, boot_low;
    logic fb_uv_aux, fb_uv_main, en_pin, pol_pin;
    logic run_aux, run_main, ss_discharge;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwm_run_supervisor #(.DELAY_CYCLES(DELAY)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .ref_ok(ref_ok),
        .uv_ok(uv_ok), .ov_trip(ov_trip), .boot_above_main(boot_above_main),
        .boot_low(boot_low), .fb_uv_aux(fb_uv_aux), .fb_uv_main(fb_uv_main),
        .en_pin(en_pin), .pol_pin(pol_pin), .run_aux(run_aux),
        .run_main(run_main), .ss_discharge(ss_discharge)
    );

    // inputs [17:8] = supply ref uv ov bam blow fa fm en pol; [7:2] wait; [1:0] aux main
    localparam logic [17:0] VEC [NVEC] = '{
        {10'b1110010010, 6'd4, 2'b10},  // R3 start
        {10'b1110100010, 6'd2, 2'b11},  // R4 main follows
        {10'b1111100010, 6'd2, 2'b00},  // R2 overvoltage
        {10'b1110100010, 6'd3, 2'b00},  // R5 no boot_low
        {10'b1110010010, 6'd2, 2'b10},  // R5 restart
        {10'b1110100010, 6'd2, 2'b11},  // R4
        {10'b1010100010, 6'd2, 2'b00},  // R2 reference bad
        {10'b1110010010, 6'd2, 2'b10},  // R5
        {10'b1110010000, 6'd4, 2'b00},  // R1 pol0 en0 blocks
        {10'b1110010001, 6'd4, 2'b10},  // R1 pol1 en0 permits
        {10'b1110010011, 6'd4, 2'b00},  // R1 pol1 en1 blocks
        {10'b1110010001, 6'd4, 2'b10},  // R1
        {10'b1100010001, 6'd2, 2'b00},  // R2 undervoltage
        {10'b1110010001, 6'd2, 2'b10},  // R5
        {10'b0110010001, 6'd2, 2'b00},  // R2 supply low
        {10'b1110010001, 6'd2, 2'b10}   // R3
    };

    task automatic apply(input logic [9:0] v);
        {supply_ok, ref_ok, uv_ok, ov_trip, boot_above_main, boot_low,
         fb_uv_aux, fb_uv_main, en_pin, pol_pin} = v;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ea, input logic em, input string req);
        checks++;
        if (run_aux !== ea || run_main !== em || ss_discharge !== !ea) begin
            fails++;
            $display("FAIL %s: aux/main/ss = %b%b%b expected %b%b%b",
                     req, run_aux, run_main, ss_discharge, ea, em, !ea);
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        apply(10'b1110010010);
        step(3);
        check(1'b0, 1'b0, "R11 reset state");
        check(1'b0, 1'b0, "R6 discharge in reset");
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][17:8]);
            step(int'(VEC[i][7:2]));
            check(VEC[i][1], VEC[i][0], $sformatf("R2/R3 vector %0d", i));
        end

        // R10: enable latency (pol1: en1 disables)
        en_pin = 1'b1; step(2);
        check(1'b1, 1'b0, "R10 no change at edge 2");
        step(1);
        check(1'b0, 1'b0, "R10 change at edge 3");
        en_pin = 1'b0; step(4);
        check(1'b1, 1'b0, "R10 re-enable");

        // R8: sub-terminal episodes
        boot_above_main = 1'b1; boot_low = 1'b0; step(2);
        check(1'b1, 1'b1, "R4 both running");
        fb_uv_aux = 1'b1; step(DELAY - 1);
        check(1'b1, 1'b1, "R8 aux flag one short");
        fb_uv_aux = 1'b0; step(2);
        check(1'b1, 1'b1, "R8 cleared without fault");
        fb_uv_main = 1'b1; step(DELAY - 1);
        check(1'b1, 1'b1, "R8 timer restarted from zero");
        step(1);
        check(1'b0, 1'b0, "R7 trip at terminal count");

        // R9: latched while flag set, toggle ignored
        boot_low = 1'b1; boot_above_main = 1'b0;
        en_pin = 1'b1; step(4); en_pin = 1'b0; step(4);
        check(1'b0, 1'b0, "R9 flag still set");
        fb_uv_main = 1'b0; step(3);
        check(1'b0, 1'b0, "R9 no toggle yet");
        boot_low = 1'b0;
        en_pin = 1'b1; step(4); en_pin = 1'b0; step(4);
        check(1'b0, 1'b0, "R9 toggle without boot_low");
        boot_low = 1'b1; step(3);
        check(1'b0, 1'b0, "R9 boot_low alone");
        uv_ok = 1'b0; step(2);
        uv_ok = 1'b1; step(2);
        check(1'b1, 1'b0, "R9 restart after uv toggle");

        // R9: second trip, restart via enable toggle
        boot_above_main = 1'b1; boot_low = 1'b0; step(2);
        check(1'b1, 1'b1, "R4 running again");
        fb_uv_aux = 1'b1; step(DELAY);
        check(1'b0, 1'b0, "R7 second trip");
        fb_uv_aux = 1'b0; boot_above_main = 1'b0; boot_low = 1'b1; step(3);
        en_pin = 1'b1; step(4);
        check(1'b0, 1'b0, "R9 disabled after toggle");
        en_pin = 1'b0; step(4);
        check(1'b1, 1'b0, "R9 restart after enable toggle");

        // R11: mid-run reset
        rst = 1'b1; step(2);
        check(1'b0, 1'b0, "R11 mid-run reset");
        rst = 1'b0; step(4);
        check(1'b1, 1'b0, "R3 start after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule